// File: doc/BRIEF.md
# Bus Slave Access Timing Controller

This block times single-word accesses from an asynchronous bus master to a peripheral chip and to a small set of configuration registers. The master's active-low data strobe passes through a two-flop synchronizer. Once the synchronized strobe goes active and the address decoder has asserted a matching select, the controller drives the active-low read or write strobe. It counts a fixed access interval on a read, or a fixed data-setup interval on a write, and then raises the acknowledge that drives the bus DTACK line.

On a read, the acknowledge and the peripheral read strobe stay asserted until the master lets go of the data strobe. The data transceiver is then switched off one cycle before the acknowledge drops. On a write, the write strobe returns high on the same edge that the acknowledge rises, so its rising edge latches the data. Each configuration register gets its own gated write clock, which goes low only when that register is selected. Every access ends with a fixed recovery interval that ignores any new strobe, and the interval closes with a one-cycle end-of-recovery pulse. If the master releases the strobe before it has been acknowledged, the access is cut short and still goes through recovery.

The access and recovery lengths are cycle-count parameters. At a 40 MHz clock, the default of 10 cycles gives 250 ns for each.

Top module: `dtack_access_timer`

## Requirements
- R1: After synchronous reset, all strobes (`per_rd_n`, `per_wr_n`, `cfg_clk_n`) are high, and `ack`, `xcvr_en` and `rec_end` are low.
- R2: A read (`rd_wr`=1 with `sel_per`=1) brings `per_rd_n` low and `xcvr_en` high on the third rising clock edge after `ds_n` falls. `ack` rises exactly ACC_CYC cycles later.
- R3: During a read, `per_rd_n` stays low and `ack` stays high for as long as the master holds `ds_n` low.
- R4: When `ds_n` is released after an acknowledged access, `xcvr_en` falls (and `per_rd_n` rises on a read) on the third edge after the release. `ack` falls one cycle after that.
- R5: A write (`rd_wr`=0) to the peripheral brings `per_wr_n` low with the same latency as R2. `per_wr_n` returns high on the same edge that `ack` rises, ACC_CYC cycles later.
- R6: A write with `sel_cfg[i]`=1 drives only `cfg_clk_n[i]` low, with the R5 timing. `per_wr_n` and the other configuration clocks stay high. At most one strobe output is low at any time.
- R7: Recovery starts on the edge where `ack` falls. After REC_CYC cycles, `rec_end` is high for exactly one cycle, and the controller is then ready for a new access.
- R8: A strobe that goes active during recovery is never serviced: no strobe output, no `ack` and no `xcvr_en`, even when it is still held after recovery ends. A fresh strobe after that is serviced normally.
- R9: If `ds_n` is released before `ack` has risen, the active strobe and `xcvr_en` return to their idle levels on the third edge after the release, `ack` never rises, and recovery still runs, ending with a `rec_end` pulse REC_CYC cycles later.
- R10: A read with only a configuration select, or any strobe with no select at all, produces no activity on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ds_n | input | 1 | Asynchronous data strobe from the bus master, active low |
| rd_wr | input | 1 | Transfer direction: 1 = read, 0 = write |
| sel_per | input | 1 | Decoded select of the peripheral chip |
| sel_cfg | input | NUM_CFG | Decoded selects of the configuration registers |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| cfg_clk_n | output | NUM_CFG | Gated write clocks of the configuration registers; rising edge latches |
| ack | output | 1 | Acknowledge; high drives DTACK active |
| xcvr_en | output | 1 | Data transceiver enable |
| rec_end | output | 1 | One-cycle pulse at the end of recovery |

## Verification
The assertions assume that no more than one select is asserted while the synchronized strobe is active. They also assume that the selects and `rd_wr` stay stable from before the strobe falls until after it rises. The bench sets the direction and exactly one select, or none, on the same falling clock edge on which it asserts `ds_n`. It holds them unchanged until the strobe has been released and the controller has finished recovery. All strobe changes fall midway between rising edges, so the synchronizer latency is always exactly two cycles, and the expected output edges can be given to the exact cycle.

// File: rtl/dat_pkg.sv
package dat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_HOLD,
    ST_DROP,
    ST_RECOV
  } acc_state_e;

endpackage

// File: rtl/dat_strobe_sync.sv
module dat_strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic active,
  output logic rise
);

  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= ~strobe_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign active = s2_q;
  assign rise   = s2_q & ~prev_q;

endmodule

// File: rtl/dat_interval_ctr.sv
module dat_interval_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/dat_seq_fsm.sv
module dat_seq_fsm
  import dat_pkg::*;
#(
  parameter int ACC_CYC = 10,
  parameter int REC_CYC = 10,
  parameter int NUM_CFG = 2,
  parameter int CW      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ds_act,
  input  logic               ds_rise,
  input  logic               rd_wr,
  input  logic               sel_per,
  input  logic [NUM_CFG-1:0] sel_cfg,
  input  logic [CW-1:0]      cnt,
  output logic               cnt_clr,
  output logic               cnt_en,
  output logic               per_rd_n,
  output logic               per_wr_n,
  output logic [NUM_CFG-1:0] cfg_clk_n,
  output logic               ack,
  output logic               xcvr_en,
  output logic               rec_end
);

  localparam int TW = NUM_CFG + 1;
  localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  acc_state_e st_q, st_d;
  logic [TW-1:0] tgt_q, tgt_d;
  logic          is_rd_q, is_rd_d;

  always_comb begin
    st_d    = st_q;
    tgt_d   = tgt_q;
    is_rd_d = is_rd_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ds_rise) begin
          if (rd_wr && sel_per) begin
            st_d    = ST_RD_ACC;
            tgt_d   = TW'(1);
            is_rd_d = 1'b1;
          end else if (!rd_wr && (sel_per || (|sel_cfg))) begin
            st_d    = ST_WR_SETUP;
            tgt_d   = {sel_cfg, sel_per};
            is_rd_d = 1'b0;
          end
        end
      end
      ST_RD_ACC, ST_WR_SETUP: begin
        if (!ds_act)               st_d = ST_RECOV;
        else if (cnt == ACC_LAST)  st_d = ST_HOLD;
      end
      ST_HOLD:  if (!ds_act) st_d = ST_DROP;
      ST_DROP:  st_d = ST_RECOV;
      ST_RECOV: if (cnt == REC_LAST) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (st_d != st_q);
  assign cnt_en  = (st_q == ST_RD_ACC) || (st_q == ST_WR_SETUP) || (st_q == ST_RECOV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      tgt_q    <= '0;
      is_rd_q  <= 1'b0;
      per_rd_n <= 1'b1;
      per_wr_n <= 1'b1;
      ack      <= 1'b0;
      xcvr_en  <= 1'b0;
      rec_end  <= 1'b0;
    end else begin
      st_q     <= st_d;
      tgt_q    <= tgt_d;
      is_rd_q  <= is_rd_d;
      per_rd_n <= !((st_d == ST_RD_ACC) || ((st_d == ST_HOLD) && is_rd_d));
      per_wr_n <= !((st_d == ST_WR_SETUP) && tgt_d[0]);
      ack      <= (st_d == ST_HOLD) || (st_d == ST_DROP);
      xcvr_en  <= (st_d == ST_RD_ACC) || (st_d == ST_WR_SETUP) || (st_d == ST_HOLD);
      rec_end  <= (st_q == ST_RECOV) && (st_d == ST_IDLE);
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) cfg_clk_n[g] <= 1'b1;
      else     cfg_clk_n[g] <= !((st_d == ST_WR_SETUP) && tgt_d[g+1]);
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    ds_act |-> $onehot0({sel_cfg, sel_per})); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~cfg_clk_n, ~per_wr_n, ~per_rd_n}) <= 1); // R6
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(ds_act)); // R3
  AST_ACC_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(cnt) == ACC_LAST); // R2
  AST_XCVR_OFF_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> $past(!xcvr_en)); // R4
  AST_WR_HIGH_AT_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> (per_wr_n && (&cfg_clk_n))); // R5
  AST_RECOV_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RECOV) |-> (per_rd_n && per_wr_n && (&cfg_clk_n) && !ack && !xcvr_en)); // R8
  AST_REC_END_PULSE: assert property (@(posedge clk) disable iff (rst)
    rec_end |=> !rec_end); // R7

endmodule

// File: rtl/dtack_access_timer.sv
module dtack_access_timer #(
  parameter int ACC_CYC = 10,
  parameter int REC_CYC = 10,
  parameter int NUM_CFG = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ds_n,
  input  logic               rd_wr,
  input  logic               sel_per,
  input  logic [NUM_CFG-1:0] sel_cfg,
  output logic               per_rd_n,
  output logic               per_wr_n,
  output logic [NUM_CFG-1:0] cfg_clk_n,
  output logic               ack,
  output logic               xcvr_en,
  output logic               rec_end
);

  localparam int MAXC = (ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          ds_act, ds_rise, cnt_clr, cnt_en;
  logic [CW-1:0] cnt;

  dat_strobe_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (ds_n),
    .active   (ds_act),
    .rise     (ds_rise)
  );

  dat_interval_ctr #(.W(CW)) u_ctr (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .en  (cnt_en),
    .cnt (cnt)
  );

  dat_seq_fsm #(
    .ACC_CYC (ACC_CYC),
    .REC_CYC (REC_CYC),
    .NUM_CFG (NUM_CFG),
    .CW      (CW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ds_act    (ds_act),
    .ds_rise   (ds_rise),
    .rd_wr     (rd_wr),
    .sel_per   (sel_per),
    .sel_cfg   (sel_cfg),
    .cnt       (cnt),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .per_rd_n  (per_rd_n),
    .per_wr_n  (per_wr_n),
    .cfg_clk_n (cfg_clk_n),
    .ack       (ack),
    .xcvr_en   (xcvr_en),
    .rec_end   (rec_end)
  );

endmodule

// File: tb/tb_dtack_access_timer.sv
module tb_dtack_access_timer;

  localparam int A = 10;
  localparam int R = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ds_n = 1'b1;
  logic       rd_wr = 1'b1;
  logic       sel_per = 1'b0;
  logic [1:0] sel_cfg = 2'b00;
  logic       per_rd_n, per_wr_n, ack, xcvr_en, rec_end;
  logic [1:0] cfg_clk_n;

  int checks = 0;
  int misses = 0;
  int cyc = 0;
  bit done = 0;

  int    qc[$];
  int    qs[$];
  bit    qv[$];
  string qr[$];

  logic [6:0] cur, prv;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  dtack_access_timer dut (
    .clk(clk), .rst(rst), .ds_n(ds_n), .rd_wr(rd_wr), .sel_per(sel_per),
    .sel_cfg(sel_cfg), .per_rd_n(per_rd_n), .per_wr_n(per_wr_n),
    .cfg_clk_n(cfg_clk_n), .ack(ack), .xcvr_en(xcvr_en), .rec_end(rec_end)
  );

  // expected output edge: signal index 0 rd,1 wr,2 cfg0,3 cfg1,4 ack,5 xcvr,6 rec_end
  task automatic push(input int c, input int s, input bit v, input string rq);
    qc.push_back(c); qs.push_back(s); qv.push_back(v); qr.push_back(rq);
  endtask

  // monitor: pops one expected item per observed output edge
  always @(negedge clk) begin
    cur = {rec_end, xcvr_en, ack, cfg_clk_n[1], cfg_clk_n[0], per_wr_n, per_rd_n};
    if (rst) prv = cur;
    else begin
      for (int i = 0; i < 7; i++) begin
        if (cur[i] !== prv[i]) begin
          checks++;
          if (qc.size() == 0) begin
            misses++;
            $display("FAIL R8/R10 unexpected edge: sig %0d -> %b at cycle %0d, expected none", i, cur[i], cyc);
          end else begin
            int c; int s; bit v; string rq;
            c = qc.pop_front(); s = qs.pop_front(); v = qv.pop_front(); rq = qr.pop_front();
            if (c != cyc || s != i || v != cur[i]) begin
              misses++;
              $display("FAIL %s: got sig %0d=%b at cycle %0d, expected sig %0d=%b at cycle %0d",
                       rq, i, cur[i], cyc, s, v, c);
            end
          end
        end
      end
      prv = cur;
    end
  end

  task automatic check_quiet(input string rq);
    checks++;
    if (qc.size() != 0 || cur !== 7'b0001111) begin
      misses++;
      $display("FAIL %s: pending=%0d outputs=%b, expected pending=0 outputs=0001111", rq, qc.size(), cur);
    end
  endtask

  // tgt: 0 peripheral, 1 cfg0, 2 cfg1, 3 none
  task automatic access(input bit rd, input int tgt, input int hold, input bit abort, input bit lock);
    int c, r, d, a, s;
    bit svc;
    svc = rd ? (tgt == 0) : (tgt < 3);
    s   = rd ? 0 : 1 + tgt;
    @(negedge clk);
    rd_wr = rd; sel_per = (tgt == 0); sel_cfg = {tgt == 2, tgt == 1};
    ds_n = 1'b0; c = cyc;
    if (!svc) begin
      repeat (hold + 3) @(negedge clk);
      ds_n = 1'b1;
      repeat (8) @(negedge clk);
      check_quiet("R10");
    end else begin
      push(c + 3, s, 1'b0, rd ? "R2" : (tgt == 0 ? "R5" : "R6"));
      push(c + 3, 5, 1'b1, "R2");
      if (abort) begin
        repeat (3) @(negedge clk);
        r = cyc; ds_n = 1'b1;
        push(r + 3, s, 1'b1, "R9");
        push(r + 3, 5, 1'b0, "R9");
        push(r + 3 + R, 6, 1'b1, "R9");
        push(r + 4 + R, 6, 1'b0, "R9");
      end else begin
        a = c + 3 + A;
        if (!rd) push(a, s, 1'b1, tgt == 0 ? "R5" : "R6");
        push(a, 4, 1'b1, rd ? "R2" : "R5");
        repeat (3 + A + hold) @(negedge clk);
        r = cyc; ds_n = 1'b1;
        d = r + 3;
        if (rd) push(d, 0, 1'b1, "R3");
        push(d, 5, 1'b0, "R4");
        push(d + 1, 4, 1'b0, "R4");
        push(d + 1 + R, 6, 1'b1, "R7");
        push(d + 2 + R, 6, 1'b0, "R7");
        if (lock) begin
          repeat (5) @(negedge clk);
          ds_n = 1'b0;
          repeat (R + 6) @(negedge clk);
          ds_n = 1'b1;
          repeat (8) @(negedge clk);
          check_quiet("R8");
          sel_per = 1'b0; sel_cfg = 2'b00;
          return;
        end
      end
      repeat (R + 8) @(negedge clk);
    end
    sel_per = 1'b0; sel_cfg = 2'b00;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({rec_end, xcvr_en, ack, cfg_clk_n, per_wr_n, per_rd_n} !== 7'b0001111) begin
      misses++;
      $display("FAIL R1: outputs=%b expected 0001111",
               {rec_end, xcvr_en, ack, cfg_clk_n, per_wr_n, per_rd_n});
    end
    access(1, 0, 3, 0, 0);   // read, R2 R3 R4 R7
    access(1, 0, 0, 0, 0);   // read, immediate release
    access(0, 0, 2, 0, 0);   // peripheral write, R5
    access(0, 1, 0, 0, 0);   // cfg0 write, R6
    access(0, 2, 4, 0, 0);   // cfg1 write, R6
    access(1, 0, 0, 1, 0);   // aborted read, R9
    access(0, 1, 0, 1, 0);   // aborted cfg write, R9
    access(1, 1, 2, 0, 0);   // read of cfg register ignored, R10
    access(0, 3, 2, 0, 0);   // no select ignored, R10
    access(1, 0, 1, 0, 1);   // strobe during recovery locked out, R8
    access(0, 0, 1, 0, 0);   // service resumes after lockout, R8
    check_quiet("R7");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
    end
  end

endmodule